// File: doc/BRIEF.md
# Dual-Slot Card Access Controller

This block lets a host drive two common-interface card slots through a small set of byte-wide registers. The host sets up a card address in two registers, chooses the slot and the address space (attribute memory or control space) in a bus control register, and then accesses the card data register. A write to the data register starts a write cycle on the shared card bus. A read from it starts a read cycle and returns the byte the card drove. Each cycle holds the chip enable, the address and one strobe for a fixed number of clocks.

The same bus control register starts slot resets, routes the transport stream through either card, and reports whether each slot holds a ready card. A reset bit reads back as 1 until the hardware reset sequence has ended. The sequence is a reset pulse of fixed length followed by a wait for the card's ready line. A second control register enables the two stream outputs and drives the two tuner reset lines. Card-detect inputs are debounced. While the interrupt is enabled, any settled change in card presence raises a pending interrupt, and a read of the interrupt register clears it.

Host handshake: the host pulses `reg_req` for one clock with `reg_we`, `reg_addr` and `reg_wdata`. It waits for the one-clock `reg_ack` before it makes the next request. `reg_rdata` is valid while `reg_ack` is high.

Top module: `card_slot_ctrl`

## Requirements
- R1: The card address on `card_addr` is {address-high[6:0], address-low[7:1], 0}. Address-low lives at offset 4 and bit 0 always reads 0. Address-high lives at offset 5 and bit 7 always reads 0. The address stays stable for the whole cycle.
- R2: Bus control (offset 7) bit 7 selects the slot (0 lowers `card_ce_n[0]`, 1 lowers `card_ce_n[1]`). Bit 6 selects control space (1, `card_ctl_space` high) or attribute memory (0). At most one chip enable is low at any time.
- R3: A write to the data register (offset 6) holds `card_we_n` and the selected chip enable low for exactly STROBE_CYC clocks, with the written byte on `card_dout`. `card_oe_n` and `card_we_n` are never low together.
- R4: A read of the data register holds `card_oe_n` low for exactly STROBE_CYC clocks. It returns the `card_din` value from the last of those clocks. `reg_ack` comes STROBE_CYC+1 clocks after the clock that samples the request.
- R5: Writing 1 to bus control bit 5 (slot 0) or bit 4 (slot 1) raises `card_rst` of that slot for exactly RST_CYC clocks. It then waits for that slot's `card_rdy`. The bit reads 1 until the wait ends and then reads 0. Writing 0 to the bit has no effect.
- R6: Bus control bit 3 drives `ts_route_en[0]` and bit 2 drives `ts_route_en[1]`. Both read back.
- R7: Bus control bit 1 reads 0 only when slot 0 holds a detected card with `card_rdy[0]` high. Bit 0 does the same for slot 1. Writes to these bits are ignored.
- R8: A change on `card_det_n` takes effect only after it has held for DEB_CYC clocks. A shorter pulse changes neither the status nor the interrupt.
- R9: Writing 0x44 to the interrupt register (offset 0) enables the interrupt, and any other value disables it. The register reads bits 6 and 2 as the enable state and bit 0 as the pending flag. A settled presence change while enabled sets the pending flag, which drives `irq`. A read of the register clears it.
- R10: Control register 2 (offset 1) bit 4 drives `ts_out_en[0]` and bit 5 drives `ts_out_en[1]`. Bit 3 drives `tuner_rst_n[0]` and bit 2 drives `tuner_rst_n[1]`. The register resets to 0x0C, so both tuners start out of reset with the outputs off.
- R11: Every register other than the data register acknowledges exactly one clock after the clock that samples the request. No card strobe or chip enable is active while no data access is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | One-clock register request |
| reg_we | input | 1 | 1 = write request, 0 = read request |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_ack | output | 1 | One-clock request completion |
| reg_rdata | output | 8 | Read data, valid with reg_ack |
| card_addr | output | 15 | Card bus address |
| card_dout | output | 8 | Card bus write data |
| card_din | input | 8 | Card bus read data |
| card_ctl_space | output | 1 | High during a control-space cycle |
| card_ce_n | output | 2 | Per-slot chip enable, active low |
| card_oe_n | output | 1 | Read strobe, active low |
| card_we_n | output | 1 | Write strobe, active low |
| card_rst | output | 2 | Per-slot card reset, active high |
| card_rdy | input | 2 | Per-slot card ready |
| card_det_n | input | 2 | Per-slot card detect, active low |
| ts_route_en | output | 2 | Per-slot stream routing enable |
| ts_out_en | output | 2 | Transport-stream output enables |
| tuner_rst_n | output | 2 | Tuner resets, active low |
| irq | output | 1 | Card-status interrupt |

## Verification
On every clock, the bound assertions check the bus-level invariants. These are: a single chip enable at a time, exclusive strobes with a chip enable behind them, strobe runs no longer than STROBE_CYC, and an address held steady through a cycle. They also check that card resets occur only inside a reset sequence, that an interrupt rises only while enabled, and that plain register requests are acknowledged one clock later. The following need the bench's scenarios: that the right byte reaches each slot and space, that data read back matches data written across the address sweep, the exact reset pulse length and the ready wait, the rejection of short detect glitches, clear-on-read of the interrupt, and the bit placement of every control field.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

  localparam int NSLOT  = 2;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  // Register offsets decoded by host software
  localparam logic [3:0] OFS_INT  = 4'd0;
  localparam logic [3:0] OFS_CTL2 = 4'd1;
  localparam logic [3:0] OFS_ALO  = 4'd4;
  localparam logic [3:0] OFS_AHI  = 4'd5;
  localparam logic [3:0] OFS_DATA = 4'd6;
  localparam logic [3:0] OFS_CTL  = 4'd7;

  localparam logic [7:0] IRQ_ENABLE_CODE = 8'h44;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_PULSE = 2'd1,
    RS_WAIT  = 2'd2
  } rs_state_t;

  typedef struct packed {
    logic              slot;
    logic              ctl_space;
    logic [ADDR_W-1:0] addr;
    logic              we;
    logic [DATA_W-1:0] wdata;
  } acc_cmd_t;

  // Card address: high register on top, low register bits 7:1, even byte
  function automatic logic [ADDR_W-1:0] join_card_addr(input logic [6:0] lo_bits,
                                                       input logic [6:0] hi_bits);
    return {hi_bits, lo_bits, 1'b0};
  endfunction

  // Bus control readback: slot, space, reset busy, routing, not-ready
  function automatic logic [7:0] ctl_readback(input logic       slot,
                                              input logic       space,
                                              input logic [1:0] rst_busy,
                                              input logic [1:0] route,
                                              input logic [1:0] nready);
    return {slot, space, rst_busy[0], rst_busy[1], route[0], route[1],
            nready[0], nready[1]};
  endfunction

  function automatic logic [7:0] ctl2_readback(input logic [1:0] ts_out,
                                               input logic [1:0] tun_n);
    return {2'b00, ts_out[1], ts_out[0], tun_n[0], tun_n[1], 2'b00};
  endfunction

  function automatic logic [7:0] irq_readback(input logic en, input logic pend);
    return {1'b0, en, 3'b000, en, 1'b0, pend};
  endfunction

endpackage

// File: rtl/cslot_debounce.sv
module cslot_debounce #(
  parameter int DEB_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_n,
  output logic present,
  output logic change
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          raw_present;

  assign raw_present = ~sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      run_q   <= '0;
      present <= 1'b0;
      change  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], det_n};
      change <= 1'b0;
      if (raw_present != present) begin
        if (run_q == CW'(DEB_CYC - 1)) begin
          present <= raw_present;
          change  <= 1'b1;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/cslot_reset_seq.sv
module cslot_reset_seq
  import cslot_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic card_rdy,
  output logic busy,
  output logic card_rst
);
  localparam int CW = $clog2(RST_CYC + 1);

  rs_state_t     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        RS_IDLE: begin
          if (start) begin
            state_q <= RS_PULSE;
            cnt_q   <= '0;
          end
        end
        RS_PULSE: begin
          if (cnt_q == CW'(RST_CYC - 1)) state_q <= RS_WAIT;
          else                           cnt_q   <= cnt_q + 1'b1;
        end
        RS_WAIT: begin
          if (card_rdy) state_q <= RS_IDLE;
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != RS_IDLE);
  assign card_rst = (state_q == RS_PULSE);
endmodule

// File: rtl/cslot_access.sv
module cslot_access
  import cslot_pkg::*;
#(
  parameter int STROBE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  acc_cmd_t          cmd,
  input  logic [DATA_W-1:0] card_din,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] card_addr,
  output logic [DATA_W-1:0] card_dout,
  output logic              card_ctl_space,
  output logic [NSLOT-1:0]  card_ce_n,
  output logic              card_oe_n,
  output logic              card_we_n
);
  localparam int CW = $clog2(STROBE_CYC + 1);

  acc_cmd_t      cmd_q;
  logic [CW-1:0] cnt_q;
  logic          last_cyc;

  assign last_cyc = busy && (cnt_q == CW'(STROBE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      cmd_q <= '0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
        cmd_q <= cmd;
      end else if (last_cyc) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (!cmd_q.we) rdata <= card_din;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_ce
    assign card_ce_n[s] = ~(busy && (cmd_q.slot == 1'(s)));
  end

  assign card_addr      = cmd_q.addr;
  assign card_dout      = cmd_q.we ? cmd_q.wdata : '0;
  assign card_ctl_space = busy & cmd_q.ctl_space;
  assign card_oe_n      = ~(busy & ~cmd_q.we);
  assign card_we_n      = ~(busy &  cmd_q.we);
endmodule

// File: rtl/card_slot_ctrl.sv
module card_slot_ctrl
  import cslot_pkg::*;
#(
  parameter int STROBE_CYC = 4,
  parameter int RST_CYC    = 16,
  parameter int DEB_CYC    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic        reg_ack,
  output logic [7:0]  reg_rdata,
  output logic [14:0] card_addr,
  output logic [7:0]  card_dout,
  input  logic [7:0]  card_din,
  output logic        card_ctl_space,
  output logic [1:0]  card_ce_n,
  output logic        card_oe_n,
  output logic        card_we_n,
  output logic [1:0]  card_rst,
  input  logic [1:0]  card_rdy,
  input  logic [1:0]  card_det_n,
  output logic [1:0]  ts_route_en,
  output logic [1:0]  ts_out_en,
  output logic [1:0]  tuner_rst_n,
  output logic        irq
);

  // Register state
  logic [6:0] alo_q, ahi_q;
  logic       slot_q, space_q;
  logic [1:0] route_q, ts_out_q, tun_n_q;
  logic       irq_en, irq_pend;
  logic       plain_ack_q;
  logic [7:0] plain_rd_q, plain_val;

  // Named internal events
  logic             is_data, wr_hit_ctl, wr_hit_ctl2, wr_hit_int;
  logic             wr_hit_alo, wr_hit_ahi;
  logic             acc_start, acc_busy, acc_done;
  logic [7:0]       acc_rdata;
  logic [NSLOT-1:0] rst_start, rst_busy, present, det_change, nready;
  logic             irq_set_evt, irq_clr_evt;
  acc_cmd_t         acc_cmd;

  assign is_data     = (reg_addr == OFS_DATA);
  assign wr_hit_ctl  = reg_req & reg_we & (reg_addr == OFS_CTL);
  assign wr_hit_ctl2 = reg_req & reg_we & (reg_addr == OFS_CTL2);
  assign wr_hit_int  = reg_req & reg_we & (reg_addr == OFS_INT);
  assign wr_hit_alo  = reg_req & reg_we & (reg_addr == OFS_ALO);
  assign wr_hit_ahi  = reg_req & reg_we & (reg_addr == OFS_AHI);
  assign acc_start   = reg_req & is_data & ~acc_busy;
  assign irq_clr_evt = reg_req & ~reg_we & (reg_addr == OFS_INT);
  assign irq_set_evt = irq_en & (|det_change);

  // Reset requests: bit 5 for slot 0, bit 4 for slot 1
  assign rst_start[0] = wr_hit_ctl & reg_wdata[5];
  assign rst_start[1] = wr_hit_ctl & reg_wdata[4];

  always_comb begin
    acc_cmd           = '0;
    acc_cmd.slot      = slot_q;
    acc_cmd.ctl_space = space_q;
    acc_cmd.addr      = join_card_addr(alo_q, ahi_q);
    acc_cmd.we        = reg_we;
    acc_cmd.wdata     = reg_wdata;
  end

  // Per-slot detect and reset logic
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    cslot_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .det_n   (card_det_n[s]),
      .present (present[s]),
      .change  (det_change[s])
    );

    cslot_reset_seq #(.RST_CYC(RST_CYC)) u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (rst_start[s]),
      .card_rdy (card_rdy[s]),
      .busy     (rst_busy[s]),
      .card_rst (card_rst[s])
    );

    assign nready[s] = ~(present[s] & card_rdy[s]);
  end

  cslot_access #(.STROBE_CYC(STROBE_CYC)) u_acc (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (acc_start),
    .cmd            (acc_cmd),
    .card_din       (card_din),
    .busy           (acc_busy),
    .done           (acc_done),
    .rdata          (acc_rdata),
    .card_addr      (card_addr),
    .card_dout      (card_dout),
    .card_ctl_space (card_ctl_space),
    .card_ce_n      (card_ce_n),
    .card_oe_n      (card_oe_n),
    .card_we_n      (card_we_n)
  );

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q    <= '0;
      ahi_q    <= '0;
      slot_q   <= 1'b0;
      space_q  <= 1'b0;
      route_q  <= '0;
      ts_out_q <= '0;
      tun_n_q  <= 2'b11;
      irq_en   <= 1'b0;
    end else begin
      if (wr_hit_alo) alo_q <= reg_wdata[7:1];
      if (wr_hit_ahi) ahi_q <= reg_wdata[6:0];
      if (wr_hit_ctl) begin
        slot_q  <= reg_wdata[7];
        space_q <= reg_wdata[6];
        route_q <= {reg_wdata[2], reg_wdata[3]};
      end
      if (wr_hit_ctl2) begin
        ts_out_q <= {reg_wdata[5], reg_wdata[4]};
        tun_n_q  <= {reg_wdata[2], reg_wdata[3]};
      end
      if (wr_hit_int) irq_en <= (reg_wdata == IRQ_ENABLE_CODE);
    end
  end

  // Interrupt pending: a new event wins over a clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           irq_pend <= 1'b0;
    else if (irq_set_evt) irq_pend <= 1'b1;
    else if (irq_clr_evt) irq_pend <= 1'b0;
  end

  // Plain register readback
  always_comb begin
    case (reg_addr)
      OFS_INT:  plain_val = irq_readback(irq_en, irq_pend);
      OFS_CTL2: plain_val = ctl2_readback(ts_out_q, tun_n_q);
      OFS_ALO:  plain_val = {alo_q, 1'b0};
      OFS_AHI:  plain_val = {1'b0, ahi_q};
      OFS_CTL:  plain_val = ctl_readback(slot_q, space_q, rst_busy, route_q, nready);
      default:  plain_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_ack_q <= 1'b0;
      plain_rd_q  <= '0;
    end else begin
      plain_ack_q <= reg_req & ~is_data;
      if (reg_req & ~is_data & ~reg_we) plain_rd_q <= plain_val;
    end
  end

  assign reg_ack     = plain_ack_q | acc_done;
  assign reg_rdata   = acc_done ? acc_rdata : plain_rd_q;
  assign ts_route_en = route_q;
  assign ts_out_en   = ts_out_q;
  assign tuner_rst_n = tun_n_q;
  assign irq         = irq_pend;

endmodule

// File: rtl/cslot_checker.sv
module cslot_checker #(
  parameter int STROBE_CYC = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  card_ce_n,
  input logic        card_oe_n,
  input logic        card_we_n,
  input logic [14:0] card_addr,
  input logic [1:0]  card_rst,
  input logic [1:0]  rst_busy,
  input logic        acc_busy,
  input logic        irq,
  input logic        irq_en,
  input logic        reg_req,
  input logic [3:0]  reg_addr,
  input logic        reg_ack
);
  int  strobe_run;
  logic strobe_on;

  assign strobe_on = ~card_oe_n | ~card_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         strobe_run <= 0;
    else if (strobe_on) strobe_run <= strobe_run + 1;
    else                strobe_run <= 0;
  end

  assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~card_ce_n));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!card_oe_n && !card_we_n));

  assert_strobe_has_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> (card_ce_n != 2'b11));

  assert_strobe_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_run <= STROBE_CYC);

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_busy && $past(acc_busy)) |-> $stable(card_addr));

  assert_rst0_in_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst[0] |-> rst_busy[0]);

  assert_rst1_in_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst[1] |-> rst_busy[1]);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));

  assert_plain_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_addr != 4'd6) |=> reg_ack);

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_busy |-> (card_ce_n == 2'b11 && card_oe_n && card_we_n));
endmodule

bind card_slot_ctrl cslot_checker #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .card_ce_n (card_ce_n),
  .card_oe_n (card_oe_n),
  .card_we_n (card_we_n),
  .card_addr (card_addr),
  .card_rst  (card_rst),
  .rst_busy  (rst_busy),
  .acc_busy  (acc_busy),
  .irq       (irq),
  .irq_en    (irq_en),
  .reg_req   (reg_req),
  .reg_addr  (reg_addr),
  .reg_ack   (reg_ack)
);

// File: tb/sim_card_slot_ctrl.sv
`timescale 1ns/1ps
module sim_card_slot_ctrl;
  localparam int SC = 3;
  localparam int RC = 3;
  localparam int DC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_ack;
  logic [7:0]  reg_rdata;
  logic [14:0] card_addr;
  logic [7:0]  card_dout, card_din;
  logic        card_ctl_space, card_oe_n, card_we_n, irq;
  logic [1:0]  card_ce_n, card_rst, ts_route_en, ts_out_en, tuner_rst_n;
  logic [1:0]  card_rdy = 2'b11;
  logic [1:0]  card_det_n = 2'b11;

  int n_cmp = 0, n_bad = 0;
  int oe_tot = 0, we_tot = 0, rst0_tot = 0, rst1_tot = 0;
  logic [1:0]  seen_ce;
  logic [14:0] seen_addr;
  logic [7:0]  seen_dout;
  logic        seen_space;
  logic [7:0]  cmem [0:63];
  logic [5:0]  midx;

  always #10 clk = ~clk;

  card_slot_ctrl #(.STROBE_CYC(SC), .RST_CYC(RC), .DEB_CYC(DC)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata), .card_addr(card_addr), .card_dout(card_dout),
    .card_din(card_din), .card_ctl_space(card_ctl_space),
    .card_ce_n(card_ce_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
    .card_rst(card_rst), .card_rdy(card_rdy), .card_det_n(card_det_n),
    .ts_route_en(ts_route_en), .ts_out_en(ts_out_en),
    .tuner_rst_n(tuner_rst_n), .irq(irq));

  // Card model: byte store indexed by slot, space, address bits 4:1
  assign midx     = {card_ce_n == 2'b01, card_ctl_space, card_addr[4:1]};
  assign card_din = (!card_oe_n) ? cmem[midx] : 8'h00;

  always @(negedge clk) begin
    if (!card_oe_n) oe_tot++;
    if (!card_we_n) begin
      we_tot++;
      cmem[midx] <= card_dout;
    end
    if (card_rst[0]) rst0_tot++;
    if (card_rst[1]) rst1_tot++;
    if (card_ce_n != 2'b11) begin
      seen_ce    = card_ce_n;
      seen_addr  = card_addr;
      seen_dout  = card_dout;
      seen_space = card_ctl_space;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_op(input logic [3:0] a, input logic w, input logic [7:0] d,
                        output logic [7:0] q, output int waited);
    @(negedge clk);
    reg_req = 1'b1; reg_we = w; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0;
    waited = 0;
    while (!reg_ack && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    q = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q; int g;
    reg_op(a, 1'b1, d, q, g);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    int g;
    reg_op(a, 1'b0, 8'h00, q, g);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int g, o0, w0, r0, r1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // Reset state
    chk("R11 idle ce", card_ce_n, 2'b11);
    chk("R11 idle strobes", {card_oe_n, card_we_n}, 2'b11);
    chk("R5 no reset", card_rst, 2'b00);
    chk("R9 irq reset", irq, 0);
    chk("R10 tuner reset value", tuner_rst_n, 2'b11);
    chk("R10 ts out reset value", ts_out_en, 2'b00);
    chk("R6 route reset value", ts_route_en, 2'b00);
    rd(4'd7, q); chk("R7 ctl reset readback", q, 8'h03);
    rd(4'd1, q); chk("R10 ctl2 reset readback", q, 8'h0C);
    reg_op(4'd1, 1'b0, 8'h00, q, g); chk("R11 plain ack delay", g, 0);

    // Address register readback
    wr(4'd4, 8'hFF); rd(4'd4, q); chk("R1 addr low bit0 zero", q, 8'hFE);
    wr(4'd5, 8'hFF); rd(4'd5, q); chk("R1 addr high bit7 zero", q, 8'h7F);

    // Write sweep across slots, spaces and addresses
    for (int s = 0; s < 2; s++)
      for (int sp = 0; sp < 2; sp++)
        for (int i = 0; i < 16; i++) begin
          int a; int v;
          a = (i + (((s*2 + sp)*37 + i*5) * 16)) & 16'h3FFF;
          v = (i*29 + s*71 + sp*113) & 8'hFF;
          wr(4'd4, 8'((a << 1) & 8'hFE));
          wr(4'd5, 8'((a >> 7) & 8'h7F));
          wr(4'd7, 8'((s << 7) | (sp << 6)));
          o0 = oe_tot; w0 = we_tot;
          wr(4'd6, 8'(v));
          chk("R3 write strobe length", we_tot - w0, SC);
          chk("R3 no read strobe on write", oe_tot - o0, 0);
          chk("R2 slot select write", seen_ce, (s == 1) ? 2'b01 : 2'b10);
          chk("R2 space select write", seen_space, sp);
          chk("R1 card address", seen_addr, (a << 1) & 16'h7FFF);
          chk("R3 write data", seen_dout, v);
        end

    // Read-back sweep
    for (int s = 0; s < 2; s++)
      for (int sp = 0; sp < 2; sp++)
        for (int i = 0; i < 16; i++) begin
          int a; int v;
          a = (i + (((s*2 + sp)*37 + i*5) * 16)) & 16'h3FFF;
          v = (i*29 + s*71 + sp*113) & 8'hFF;
          wr(4'd4, 8'((a << 1) & 8'hFE));
          wr(4'd5, 8'((a >> 7) & 8'h7F));
          wr(4'd7, 8'((s << 7) | (sp << 6)));
          o0 = oe_tot; w0 = we_tot;
          reg_op(4'd6, 1'b0, 8'h00, q, g);
          chk("R4 read data", q, v);
          chk("R4 read strobe length", oe_tot - o0, SC);
          chk("R4 ack delay", g, SC);
          chk("R4 no write strobe on read", we_tot - w0, 0);
          chk("R2 slot select read", seen_ce, (s == 1) ? 2'b01 : 2'b10);
        end

    // Stream routing bits
    wr(4'd7, 8'h08); chk("R6 route slot0", ts_route_en, 2'b01);
    rd(4'd7, q); chk("R6 route readback", q & 8'h0C, 8'h08);
    wr(4'd7, 8'h04); chk("R6 route slot1", ts_route_en, 2'b10);
    wr(4'd7, 8'h00);

    // Control register 2 fields
    wr(4'd1, 8'h30);
    chk("R10 ts out both", ts_out_en, 2'b11);
    chk("R10 tuners held", tuner_rst_n, 2'b00);
    wr(4'd1, 8'h18);
    chk("R10 ts out bit4", ts_out_en, 2'b01);
    chk("R10 tuner bit3", tuner_rst_n, 2'b01);
    rd(4'd1, q); chk("R10 readback", q, 8'h18);
    wr(4'd1, 8'h0C);

    // Slot resets
    card_rdy = 2'b00;
    r0 = rst0_tot; r1 = rst1_tot;
    wr(4'd7, 8'h20);
    idle(RC + 4);
    chk("R5 slot0 pulse length", rst0_tot - r0, RC);
    chk("R5 slot1 untouched", rst1_tot - r1, 0);
    rd(4'd7, q); chk("R5 slot0 bit held while waiting", q[5], 1);
    wr(4'd7, 8'h00);
    rd(4'd7, q); chk("R5 writing zero ignored", q[5], 1);
    card_rdy[0] = 1'b1;
    idle(3);
    rd(4'd7, q); chk("R5 slot0 bit clears", q[5], 0);
    r1 = rst1_tot;
    wr(4'd7, 8'h10);
    idle(RC + 4);
    chk("R5 slot1 pulse length", rst1_tot - r1, RC);
    rd(4'd7, q); chk("R5 slot1 bit held", q[4], 1);
    card_rdy[1] = 1'b1;
    idle(3);
    rd(4'd7, q); chk("R5 slot1 bit clears", q[4], 0);

    // Presence status and debouncing (interrupt disabled)
    card_det_n[0] = 1'b0;
    idle(DC + 8);
    rd(4'd7, q); chk("R7 slot0 present ready", q[1:0], 2'b01);
    chk("R9 no irq while disabled", irq, 0);
    rd(4'd0, q); chk("R9 no pending while disabled", q, 8'h00);
    card_det_n[1] = 1'b0; idle(2); card_det_n[1] = 1'b1;
    idle(DC + 8);
    rd(4'd7, q); chk("R8 glitch rejected", q[1:0], 2'b01);
    card_rdy[0] = 1'b0; idle(1);
    rd(4'd7, q); chk("R7 present but not ready", q[1:0], 2'b11);
    card_rdy[0] = 1'b1;
    wr(4'd7, 8'h03);
    rd(4'd7, q); chk("R7 status write ignored", q, 8'h01);

    // Interrupt
    wr(4'd0, 8'h44);
    rd(4'd0, q); chk("R9 enable readback", q, 8'h44);
    card_det_n[1] = 1'b0;
    idle(DC + 8);
    chk("R9 irq raised", irq, 1);
    rd(4'd7, q); chk("R7 both present", q[1:0], 2'b00);
    rd(4'd0, q); chk("R9 pending read", q, 8'h45);
    chk("R9 cleared by read", irq, 0);
    rd(4'd0, q); chk("R9 pending gone", q, 8'h44);
    card_det_n[0] = 1'b1; idle(2); card_det_n[0] = 1'b0;
    idle(DC + 8);
    chk("R8 glitch gives no irq", irq, 0);
    wr(4'd0, 8'h40);
    rd(4'd0, q); chk("R9 other value disables", q, 8'h00);
    card_det_n[1] = 1'b1;
    idle(DC + 8);
    chk("R9 disabled no irq", irq, 0);
    rd(4'd7, q); chk("R7 slot1 removed", q[1:0], 2'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule